// File: doc/BRIEF.md
# Programmable Window Strobe Generator

This block drives a bank of general-purpose control strobes for a raster display pipeline. Each strobe is active inside a rectangle of the frame. The rectangle is set by a first line, a line count, a first pixel and a width counted in pairs of pixel clocks. A position tracker outside the block supplies the current line and pixel numbers. It also supplies a one-cycle pulse at the start of every line and every frame. Three control bits per strobe select output inversion, a one-pixel late start and mixing with a phase signal. That phase signal alternates from line to line and from frame to frame.

Settings arrive on a simple register-write port. Each write selects a channel and a field. Writes go to a holding bank. The holding bank is copied into the working bank on a frame-start pulse, so a rectangle never changes partway through a frame. Every strobe comes from one output register, and all strobes update together on the rising clock.

Top module: `win_strobe_gen`

## Requirements
- R1: While `rst` is high every strobe is 0, and every setting and the phase return to 0. With all-zero settings, every strobe reads 1 from the first cycle after reset is released.
- R2: With a nonzero line count L and first line S, the vertical term is true exactly when S <= `line_num` < S+L.
- R3: A line count of 0 makes the vertical term true on every line.
- R4: With a nonzero width W and first pixel H, the horizontal term is true exactly when H <= `pix_num` < H+2W.
- R5: A width of 0 makes the horizontal term true on every pixel.
- R6: Control bit 1 (shift) moves the horizontal window one pixel later, to H+1 <= `pix_num` < H+1+2W. It has no effect when the width is 0.
- R7: Control bit 0 (invert) inverts the strobe.
- R8: Control bit 2 (mix) XORs the window term with the phase. The phase is 0 after reset. It flips once for each of `line_start` and `frame_start` that is high in a cycle, so it is unchanged when both are high together. The flipped value already applies in the cycle that carries the pulse. The strobe equals (V AND H) XOR (mix AND phase) XOR invert.
- R9: A write changes only the holding bank. A cycle with `frame_start` high is evaluated with the holding bank, and the holding bank is copied into the working bank at that edge. A write made in that same cycle waits for the next frame start.
- R10: Field codes on `wr_field` are 0 first line, 1 line count, 2 first pixel, 3 width, 4 control. Writes with a field code above 4, or with a `wr_sel` of `NUM_OUT` or higher, change nothing.
- R11: Each strobe reflects the inputs sampled at the previous rising edge (one register of latency) and is steady between edges.
- R12: Every channel uses only its own settings. Programming one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| line_num | input | LINE_W | Current line number from the position tracker |
| pix_num | input | PIX_W | Current pixel number from the position tracker |
| line_start | input | 1 | One-cycle pulse at the first pixel of each line |
| frame_start | input | 1 | One-cycle pulse at the first pixel of each frame; commits settings |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_sel | input | SEL_W | Channel number to write |
| wr_field | input | 3 | Field code (see R10) |
| wr_data | input | DATA_W | Write value, right-aligned |
| strobe | output | NUM_OUT | Registered window strobes, bit i for channel i |

## Verification
The bench builds the block with its default parameters: nine channels, 11-bit line and pixel numbers and a 10-bit first-pixel field. With nine channels the 4-bit channel select leaves codes 9 to 15 free. Writes to those codes are therefore reachable, and the bench uses them to show that stray writes land nowhere. Line and pixel values stay small. The comparisons are relative to programmed edges, so windows near line 5 and pixel 10 exercise every boundary. The full bit vector is compared on every cycle, so any spill between channels shows up at once.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [2:0] {
    FLD_VSTART = 3'd0,
    FLD_VLEN   = 3'd1,
    FLD_HSTART = 3'd2,
    FLD_HLEN   = 3'd3,
    FLD_CTRL   = 3'd4
  } fld_e;

  localparam int CTRL_W     = 3;
  localparam int CTRL_INV   = 0;
  localparam int CTRL_SHIFT = 1;
  localparam int CTRL_MIX   = 2;
endpackage

// File: rtl/wsg_cfg_bank.sv
module wsg_cfg_bank
  import wsg_pkg::*;
#(
  parameter int N      = 9,
  parameter int LINE_W = 11,
  parameter int HS_W   = 10,
  parameter int HD_W   = 11,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_start,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [2:0]                    wr_field,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [N-1:0][LINE_W-1:0]      eff_vs,
  output logic [N-1:0][LINE_W-1:0]      eff_vl,
  output logic [N-1:0][HS_W-1:0]        eff_hs,
  output logic [N-1:0][HD_W-1:0]        eff_hl,
  output logic [N-1:0][CTRL_W-1:0]      eff_ct
);
  logic [N-1:0][LINE_W-1:0] pnd_vs, pnd_vl, act_vs, act_vl;
  logic [N-1:0][HS_W-1:0]   pnd_hs, act_hs;
  logic [N-1:0][HD_W-1:0]   pnd_hl, act_hl;
  logic [N-1:0][CTRL_W-1:0] pnd_ct, act_ct;

  // holding bank: written by the port, never read by the window logic directly
  always_ff @(posedge clk) begin
    if (rst) begin
      pnd_vs <= '0;
      pnd_vl <= '0;
      pnd_hs <= '0;
      pnd_hl <= '0;
      pnd_ct <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel == SEL_W'(i)) begin
          case (wr_field)
            FLD_VSTART: pnd_vs[i] <= wr_data[LINE_W-1:0];
            FLD_VLEN:   pnd_vl[i] <= wr_data[LINE_W-1:0];
            FLD_HSTART: pnd_hs[i] <= wr_data[HS_W-1:0];
            FLD_HLEN:   pnd_hl[i] <= wr_data[HD_W-1:0];
            FLD_CTRL:   pnd_ct[i] <= wr_data[CTRL_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // working bank: loaded only at frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      act_vs <= '0;
      act_vl <= '0;
      act_hs <= '0;
      act_hl <= '0;
      act_ct <= '0;
    end else if (frame_start) begin
      act_vs <= pnd_vs;
      act_vl <= pnd_vl;
      act_hs <= pnd_hs;
      act_hl <= pnd_hl;
      act_ct <= pnd_ct;
    end
  end

  // the frame-start cycle already sees the settings being committed
  always_comb begin
    eff_vs = frame_start ? pnd_vs : act_vs;
    eff_vl = frame_start ? pnd_vl : act_vl;
    eff_hs = frame_start ? pnd_hs : act_hs;
    eff_hl = frame_start ? pnd_hl : act_hl;
    eff_ct = frame_start ? pnd_ct : act_ct;
  end

  // R9
  commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (act_vs == $past(pnd_vs)) && (act_hl == $past(pnd_hl))
                    && (act_ct == $past(pnd_ct)));

  // R9
  hold_midframe_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act_vs) && $stable(act_vl) && $stable(act_hs)
                     && $stable(act_hl) && $stable(act_ct));

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_field > 3'd4 || wr_sel >= SEL_W'(N)) |=>
      $stable(pnd_vs) && $stable(pnd_vl) && $stable(pnd_hs)
      && $stable(pnd_hl) && $stable(pnd_ct));
endmodule

// File: rtl/wsg_phase.sv
module wsg_phase (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic frame_start,
  output logic phase_now
);
  logic phase_q;

  assign phase_now = phase_q ^ line_start ^ frame_start;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= phase_now;
  end

  // R8
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start != frame_start) |=> (phase_q != $past(phase_q)));

  // R8
  phase_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start == frame_start) |=> $stable(phase_q));
endmodule

// File: rtl/wsg_window.sv
module wsg_window
  import wsg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int PIX_W  = 11,
  parameter int HS_W   = 10,
  parameter int HD_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_num,
  input  logic [PIX_W-1:0]  pix_num,
  input  logic [LINE_W-1:0] vs,
  input  logic [LINE_W-1:0] vl,
  input  logic [HS_W-1:0]   hs,
  input  logic [HD_W-1:0]   hl,
  input  logic [CTRL_W-1:0] ct,
  input  logic              phase,
  output logic              out_q
);
  localparam int BIG = (PIX_W > HD_W + 1) ? PIX_W : HD_W + 1;
  localparam int EW  = ((BIG > HS_W) ? BIG : HS_W) + 2;

  logic [LINE_W:0] v_end;
  logic [EW-1:0]   h_first, h_end, px;
  logic            v_in, h_in, out_d;

  always_comb begin
    v_end   = {1'b0, vs} + {1'b0, vl};
    v_in    = (vl == '0) ||
              (({1'b0, line_num} >= {1'b0, vs}) && ({1'b0, line_num} < v_end));
    h_first = EW'(hs) + EW'(ct[CTRL_SHIFT]);
    h_end   = h_first + (EW'(hl) << 1);
    px      = EW'(pix_num);
    h_in    = (hl == '0) || ((px >= h_first) && (px < h_end));
    out_d   = (v_in & h_in) ^ (ct[CTRL_MIX] & phase) ^ ct[CTRL_INV];
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= out_d;
  end

  // R3 R5
  always_on_chk: assert property (@(posedge clk) disable iff (rst)
    (vl == '0 && hl == '0 && ct == '0) |=> out_q);

  // R2
  above_window_chk: assert property (@(posedge clk) disable iff (rst)
    (vl != '0 && line_num < vs && ct == '0) |=> !out_q);

  // R7
  invert_full_chk: assert property (@(posedge clk) disable iff (rst)
    (vl == '0 && hl == '0 && ct == CTRL_W'(1 << CTRL_INV)) |=> !out_q);
endmodule

// File: rtl/win_strobe_gen.sv
module win_strobe_gen
  import wsg_pkg::*;
#(
  parameter int NUM_OUT = 9,
  parameter int LINE_W  = 11,
  parameter int PIX_W   = 11,
  parameter int HS_W    = 10,
  parameter int HD_W    = 11,
  localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int W1     = (LINE_W > HD_W) ? LINE_W : HD_W,
  localparam int W2     = (W1 > HS_W) ? W1 : HS_W,
  localparam int DATA_W = (W2 > CTRL_W) ? W2 : CTRL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINE_W-1:0]  line_num,
  input  logic [PIX_W-1:0]   pix_num,
  input  logic               line_start,
  input  logic               frame_start,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [2:0]         wr_field,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_OUT-1:0] strobe
);
  logic [NUM_OUT-1:0][LINE_W-1:0] e_vs, e_vl;
  logic [NUM_OUT-1:0][HS_W-1:0]   e_hs;
  logic [NUM_OUT-1:0][HD_W-1:0]   e_hl;
  logic [NUM_OUT-1:0][CTRL_W-1:0] e_ct;
  logic                           phase;

  wsg_cfg_bank #(
    .N(NUM_OUT), .LINE_W(LINE_W), .HS_W(HS_W), .HD_W(HD_W),
    .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_field(wr_field), .wr_data(wr_data),
    .eff_vs(e_vs), .eff_vl(e_vl), .eff_hs(e_hs), .eff_hl(e_hl), .eff_ct(e_ct)
  );

  wsg_phase u_phase (
    .clk(clk), .rst(rst), .line_start(line_start),
    .frame_start(frame_start), .phase_now(phase)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
    wsg_window #(
      .LINE_W(LINE_W), .PIX_W(PIX_W), .HS_W(HS_W), .HD_W(HD_W)
    ) u_win (
      .clk(clk), .rst(rst), .line_num(line_num), .pix_num(pix_num),
      .vs(e_vs[g]), .vl(e_vl[g]), .hs(e_hs[g]), .hl(e_hl[g]), .ct(e_ct[g]),
      .phase(phase), .out_q(strobe[g])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (strobe == '0));
endmodule

// File: tb/win_strobe_gen_tb.sv
module win_strobe_gen_tb;
  localparam int N = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] line_num = '0;
  logic [10:0] pix_num = '0;
  logic        line_start = 1'b0;
  logic        frame_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [2:0]  wr_field = '0;
  logic [10:0] wr_data = '0;
  logic [N-1:0] strobe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int p_vs[N], p_vl[N], p_hs[N], p_hl[N], p_ct[N];
  int a_vs[N], a_vl[N], a_hs[N], a_hl[N], a_ct[N];
  logic m_ph = 1'b0;
  logic [N-1:0] last_exp = '0;

  always #2 clk = ~clk;

  win_strobe_gen u_dut (
    .clk(clk), .rst(rst), .line_num(line_num), .pix_num(pix_num),
    .line_start(line_start), .frame_start(frame_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_field(wr_field), .wr_data(wr_data),
    .strobe(strobe)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: strobe=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock with the inputs as currently driven, then compare
  task automatic step(string tag);
    logic [N-1:0] exp;
    logic ph;
    ph = m_ph ^ line_start ^ frame_start;
    for (int i = 0; i < N; i++) begin
      int vs, vl, hs, hl, ct, first;
      logic v, h;
      vs = frame_start ? p_vs[i] : a_vs[i];
      vl = frame_start ? p_vl[i] : a_vl[i];
      hs = frame_start ? p_hs[i] : a_hs[i];
      hl = frame_start ? p_hl[i] : a_hl[i];
      ct = frame_start ? p_ct[i] : a_ct[i];
      first = hs + ((ct >> 1) & 1);
      v = (vl == 0) || (int'(line_num) >= vs && int'(line_num) < vs + vl);
      h = (hl == 0) || (int'(pix_num) >= first && int'(pix_num) < first + 2 * hl);
      exp[i] = (v & h) ^ (((ct >> 2) & 1) == 1 && ph) ^ ((ct & 1) == 1);
    end
    @(posedge clk);
    if (frame_start) begin
      for (int i = 0; i < N; i++) begin
        a_vs[i] = p_vs[i]; a_vl[i] = p_vl[i]; a_hs[i] = p_hs[i];
        a_hl[i] = p_hl[i]; a_ct[i] = p_ct[i];
      end
    end
    m_ph = ph;
    if (wr_en && int'(wr_sel) < N) begin
      case (wr_field)
        3'd0: p_vs[wr_sel] = int'(wr_data);
        3'd1: p_vl[wr_sel] = int'(wr_data);
        3'd2: p_hs[wr_sel] = int'(wr_data) & 1023;
        3'd3: p_hl[wr_sel] = int'(wr_data);
        3'd4: p_ct[wr_sel] = int'(wr_data) & 7;
        default: ;
      endcase
    end
    #1;
    last_exp = exp;
    check(tag, strobe, exp);
  endtask

  task automatic idle();
    wr_en = 0; line_start = 0; frame_start = 0;
  endtask

  task automatic wr(int ch, int fld, int val, string tag);
    wr_en = 1; wr_sel = 4'(ch); wr_field = 3'(fld); wr_data = 11'(val);
    step(tag);
    wr_en = 0;
  endtask

  task automatic commit(string tag);
    frame_start = 1; line_num = 0; pix_num = 0;
    step(tag);
    frame_start = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin
      p_vs[i] = 0; p_vl[i] = 0; p_hs[i] = 0; p_hl[i] = 0; p_ct[i] = 0;
      a_vs[i] = 0; a_vl[i] = 0; a_hs[i] = 0; a_hl[i] = 0; a_ct[i] = 0;
    end
    rst = 1; line_start = 1; line_num = 7;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", strobe, '0);
    rst = 0; line_start = 0; m_ph = 0;
    step("R1 defaults after release");
    check("R1 all high", strobe, '1);
  endtask

  task automatic t_vertical();
    wr(0, 0, 5, "R9 write"); wr(0, 1, 3, "R9 write");
    wr(1, 0, 5, "R9 write"); wr(1, 1, 0, "R9 write");
    commit("R9 commit");
    for (int l = 3; l <= 9; l++) begin
      line_num = 11'(l); pix_num = 11'(l * 3);
      step("R2 R3 vertical sweep");
    end
  endtask

  task automatic t_horizontal();
    wr(2, 2, 10, "R12 write"); wr(2, 3, 4, "R12 write");
    wr(3, 2, 10, "R12 write"); wr(3, 3, 0, "R12 write");
    wr(4, 2, 10, "R12 write"); wr(4, 3, 4, "R12 write"); wr(4, 4, 2, "R12 write");
    wr(5, 2, 10, "R12 write"); wr(5, 3, 4, "R12 write"); wr(5, 4, 1, "R12 write");
    wr(8, 3, 0, "R12 write"); wr(8, 4, 2, "R12 write");
    commit("R9 commit");
    line_num = 2;
    for (int p = 8; p <= 20; p++) begin
      pix_num = 11'(p);
      step("R4 R5 R6 R7 horizontal sweep");
    end
  endtask

  task automatic t_mix();
    wr(6, 4, 4, "R8 write");
    wr(7, 4, 5, "R8 write");
    commit("R8 frame pulse");
    step("R8 quiet");
    line_start = 1; step("R8 line pulse"); line_start = 0;
    step("R8 quiet");
    line_start = 1; frame_start = 1; step("R8 both pulses"); idle();
    line_start = 1; step("R8 line pulse"); line_start = 0;
    frame_start = 1; step("R8 frame pulse"); frame_start = 0;
    step("R8 quiet");
  endtask

  task automatic t_shadow();
    wr(7, 0, 100, "R9 write"); wr(7, 1, 1, "R9 write"); wr(7, 4, 0, "R9 write");
    line_num = 3; pix_num = 4;
    step("R9 not yet applied");
    step("R9 not yet applied");
    frame_start = 1; line_num = 0; pix_num = 0;
    wr_en = 1; wr_sel = 7; wr_field = 0; wr_data = 0;
    step("R9 applied in commit cycle, same-cycle write held");
    idle();
    line_num = 100; step("R9 window at line 100");
    line_num = 0; step("R9 line 0 still outside");
    commit("R9 held write now applied");
  endtask

  task automatic t_ignored();
    wr(9, 1, 7, "R10 select 9");
    wr(15, 4, 1, "R10 select 15");
    wr(0, 5, 1, "R10 field 5");
    wr(1, 7, 1, "R10 field 7");
    commit("R10 commit after stray writes");
    line_num = 6; pix_num = 12;
    step("R10 unchanged");
  endtask

  task automatic t_latency();
    line_num = 2; pix_num = 0; step("R11 setup");
    line_num = 6; pix_num = 12;
    #1;
    check("R11 no change before edge", strobe, last_exp);
    step("R11 change after edge");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_vertical();
    t_horizontal();
    t_mix();
    t_shadow();
    t_ignored();
    t_latency();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule